// File: doc/BRIEF.md
# Hashed Page Table Walker

The walker turns an effective address into a real address by searching a page table held in memory. It is given a segment descriptor, the effective address, a primary hash that has already been computed, the table configuration word, and two flags: problem state and write access. On `start_i` it forms the address of an entry group and reads the entries one doubleword at a time over a req/ack read port. It compares each entry's first doubleword under a field mask. If the primary group holds no match, it searches the secondary group once.

On a hit it decodes the access rights from the second doubleword and forms the real address. It updates the referenced and changed bits in memory with single-byte writes on a separate req/ack byte-write port. The walk ends with a one-cycle `done_o` that carries a status code. Computing the hash and looking up the segment are done elsewhere.

Top module: `hpt_walker`

## Requirements
- R1: The group byte address is formed as follows. The size mask is (1 << (tbl_cfg[4:0] + 11)) - 1. The hash is cut to its low 39 bits, ANDed with the size mask and shifted left by 7. The result is ORed with tbl_cfg after bits 17:0 of tbl_cfg are cleared. Entry k sits at group + 16*k. Its first doubleword is at +0 and its second at +8.
- R2: The expected first doubleword is built as follows:
  - The page shift is 12 for page-size code 0, 16 for code 1, and 24 otherwise.
  - The segment shift is 40 for a 1T segment and 28 otherwise.
  - The page value is (ea masked to the segment shift) >> page shift, ORed with vsid << (segment shift - page shift).
  - That value is shifted right by 4 for a 12-bit page shift and left by 8 for a 24-bit page shift.
  - The shifted value is kept in bits 61:7. Bits 63:62 hold 01 for a 1T segment and 00 otherwise. Bit 2 is set when the page-size code is non-zero. Bit 1 is the secondary flag. Bit 0, the valid bit, is always set.
  - An entry matches when its first doubleword, masked to bits 63:62, 61:7 and 2:0, equals this expected value. Entries are scanned from 0 to 7, and the first match wins.
- R3: When the primary group has no match, the secondary group is searched with the bitwise complement of the hash. It requires bit 1 of the first doubleword to be set. When both groups miss, the walk ends with status 1 (not found).
- R4: For a non-zero page-size code, the second doubleword of a tag match is checked before the entry is used. Code 1 needs bits 15:12 equal to 1. Other codes need bits 19:12 equal to 0. An entry that fails this check is skipped.
- R5: The key is 1 when problem state is set and kp is set, or when problem state is clear and ks is set. The 4-bit code is {bit 63, key, bits 1:0} of the second doubleword. Codes 0, 1, 2 and 6 allow read and write. Codes 3, 5, 7 and 10 allow read only. All other codes allow nothing.
- R6: Execute is allowed exactly when bit 2 of the second doubleword is clear.
- R7: The real address takes bits 59:12 of the second doubleword above the page offset. It takes the effective-address bits below it, with the offset being 12, 16 or 24 bits per the page-size code.
- R8: On a readable hit with bit 8 (R) clear, one byte is written at second-doubleword address + 6. The byte equals bits 15:8 of the second doubleword with R set.
- R9: On a write access to a writable page with bit 7 (C) clear, one byte is written at second-doubleword address + 7. The byte equals bits 7:0 with C set. This write comes after any R write.
- R10: The status at `done_o` is one of three codes:
  - 0 (ok) when the page is readable and, for a write access, writable;
  - 2 (permission) for any other hit;
  - 1 (not found) when both groups miss.
- R11: `busy_o` is high from the cycle after `start_i` through the one-cycle `done_o`. A request is held, with a stable address, until its acknowledge. The two ports never request at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a walk (taken when idle) |
| seg_vsid_i | input | VSID_W | Segment virtual id |
| seg_1t_i | input | 1 | 1T segment |
| seg_psize_i | input | 2 | Base page size code |
| seg_ks_i | input | 1 | Supervisor key |
| seg_kp_i | input | 1 | Problem-state key |
| ea_i | input | 64 | Effective address |
| hash_i | input | 64 | Primary hash |
| tbl_cfg_i | input | 64 | Table base and size code |
| prob_i | input | 1 | Problem state |
| write_i | input | 1 | Write access |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Walk finished pulse |
| status_o | output | 2 | 0 ok, 1 not found, 2 permission |
| raddr_o | output | 64 | Real address |
| may_read_o | output | 1 | Read allowed |
| may_write_o | output | 1 | Write allowed |
| may_exec_o | output | 1 | Execute allowed |
| rd_req_o | output | 1 | Doubleword read request |
| rd_addr_o | output | 64 | Read byte address |
| rd_ack_i | input | 1 | Read acknowledge |
| rd_data_i | input | 64 | Read doubleword value |
| wr_req_o | output | 1 | Byte write request |
| wr_addr_o | output | 64 | Write byte address |
| wr_byte_o | output | 8 | Write byte |
| wr_ack_i | input | 1 | Write acknowledge |

## Verification
The bench builds the walker with its default parameters: eight entries per group, a 39-bit hash cut and a 52-bit vsid. With eight entries, a full scan of one group and the switch to the secondary group take a predictable number of reads. The bench drives the table size code up to 31, which makes the size mask wider than the hash cut, so bits above the cut must drop out of the group address. Tests with 1T segments and with all three page sizes cover each shift in the expected-tag path.

// File: rtl/hpt_walker_pkg.sv
package hpt_walker_pkg;
  typedef enum logic [1:0] {
    ST_OK        = 2'd0,
    ST_NOT_FOUND = 2'd1,
    ST_PERM      = 2'd2
  } walk_status_e;

  localparam logic [63:0] TAG_AVPN_M = 64'h3fff_ffff_ffff_ff80;
  localparam logic [63:0] TAG_SEG_M  = 64'hc000_0000_0000_0000;
  localparam logic [63:0] TAG_1T     = 64'h4000_0000_0000_0000;
  localparam logic [63:0] RPN_M      = 64'h0fff_ffff_ffff_f000;

  function automatic logic [4:0] pg_shift(input logic [1:0] code);
    case (code)
      2'd0:    pg_shift = 5'd12;
      2'd1:    pg_shift = 5'd16;
      default: pg_shift = 5'd24;
    endcase
  endfunction
endpackage

// File: rtl/hpt_group_addr.sv
module hpt_group_addr #(
  parameter int HASH_W = 39
) (
  input  logic [63:0] hash_i,
  input  logic        sec_i,
  input  logic [63:0] tbl_cfg_i,
  output logic [63:0] grp_addr_o
);
  localparam logic [63:0] HASH_M = (64'd1 << HASH_W) - 64'd1;

  logic [63:0] h, size_m;

  always_comb begin
    h          = sec_i ? ~hash_i : hash_i;
    size_m     = (64'd1 << ({1'b0, tbl_cfg_i[4:0]} + 6'd11)) - 64'd1;
    grp_addr_o = (((h & HASH_M) & size_m) << 7) | (tbl_cfg_i & ~64'h3_ffff);
  end
endmodule

// File: rtl/hpt_entry_match.sv
module hpt_entry_match
  import hpt_walker_pkg::*;
#(
  parameter int VSID_W = 52
) (
  input  logic [VSID_W-1:0] vsid_i,
  input  logic [63:0]       ea_i,
  input  logic              seg_1t_i,
  input  logic [1:0]        psize_i,
  input  logic              sec_i,
  input  logic [63:0]       dw0_i,
  input  logic [63:0]       dw1_i,
  output logic              tag_hit_o,
  output logic              size_ok_o
);
  logic [4:0]  ps;
  logic [5:0]  sh;
  logic [63:0] off_m, avpn, exp_w, cmp_m;

  always_comb begin
    ps    = pg_shift(psize_i);
    sh    = seg_1t_i ? 6'd40 : 6'd28;
    off_m = (64'd1 << sh) - 64'd1;
    avpn  = ((ea_i & off_m) >> ps) | (64'(vsid_i) << (sh - {1'b0, ps}));
    case (psize_i)
      2'd0:    avpn = avpn >> 4;
      2'd1:    avpn = avpn;
      default: avpn = avpn << 8;
    endcase
    exp_w = (avpn & TAG_AVPN_M) | (seg_1t_i ? TAG_1T : 64'd0)
          | {61'd0, psize_i != 2'd0, sec_i, 1'b1};
    cmp_m = TAG_SEG_M | TAG_AVPN_M | 64'h7;
    tag_hit_o = (dw0_i & cmp_m) == exp_w;
    case (psize_i)
      2'd0:    size_ok_o = 1'b1;
      2'd1:    size_ok_o = dw1_i[15:12] == 4'h1;
      default: size_ok_o = dw1_i[19:12] == 8'h00;
    endcase
  end
endmodule

// File: rtl/hpt_rights.sv
module hpt_rights
  import hpt_walker_pkg::*;
(
  input  logic [63:0] dw1_i,
  input  logic [63:0] ea_i,
  input  logic [1:0]  psize_i,
  input  logic        prob_i,
  input  logic        ks_i,
  input  logic        kp_i,
  output logic        may_read_o,
  output logic        may_write_o,
  output logic        may_exec_o,
  output logic [63:0] raddr_o
);
  logic        key;
  logic [3:0]  code;
  logic [63:0] off_m;

  always_comb begin
    key         = (prob_i & kp_i) | (~prob_i & ks_i);
    code        = {dw1_i[63], key, dw1_i[1:0]};
    may_read_o  = 1'b0;
    may_write_o = 1'b0;
    case (code)
      4'd0, 4'd1, 4'd2, 4'd6: begin may_read_o = 1'b1; may_write_o = 1'b1; end
      4'd3, 4'd5, 4'd7, 4'd10: may_read_o = 1'b1;
      default: ;
    endcase
    may_exec_o = ~dw1_i[2];
    off_m      = (64'd1 << pg_shift(psize_i)) - 64'd1;
    raddr_o    = (dw1_i & RPN_M & ~off_m) | (ea_i & off_m);
  end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hpt_walker_pkg::*;
#(
  parameter int VSID_W  = 52,
  parameter int HASH_W  = 39,
  parameter int NUM_ENT = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [VSID_W-1:0] seg_vsid_i,
  input  logic              seg_1t_i,
  input  logic [1:0]        seg_psize_i,
  input  logic              seg_ks_i,
  input  logic              seg_kp_i,
  input  logic [63:0]       ea_i,
  input  logic [63:0]       hash_i,
  input  logic [63:0]       tbl_cfg_i,
  input  logic              prob_i,
  input  logic              write_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        status_o,
  output logic [63:0]       raddr_o,
  output logic              may_read_o,
  output logic              may_write_o,
  output logic              may_exec_o,
  output logic              rd_req_o,
  output logic [63:0]       rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [63:0]       rd_data_i,
  output logic              wr_req_o,
  output logic [63:0]       wr_addr_o,
  output logic [7:0]        wr_byte_o,
  input  logic              wr_ack_i
);
  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENT - 1);

  typedef enum logic [2:0] {S_IDLE, S_RD0, S_RD1, S_EVAL, S_WR, S_WC, S_FIN} walk_state_e;

  walk_state_e       state_q;
  logic [VSID_W-1:0] vsid_q;
  logic              t1_q, ks_q, kp_q, pr_q, wr_q, sec_q, nf_q;
  logic [1:0]        ps_q;
  logic [63:0]       ea_q, hash_q, cfg_q, dw1_q;
  logic [IDX_W-1:0]  idx_q;
  logic [63:0]       grp_addr, ent_addr;
  logic              tag_hit, size_ok, need_r, need_c;

  hpt_group_addr #(.HASH_W(HASH_W)) u_grp (
    .hash_i(hash_q), .sec_i(sec_q), .tbl_cfg_i(cfg_q), .grp_addr_o(grp_addr)
  );

  hpt_entry_match #(.VSID_W(VSID_W)) u_match (
    .vsid_i(vsid_q), .ea_i(ea_q), .seg_1t_i(t1_q), .psize_i(ps_q), .sec_i(sec_q),
    .dw0_i(rd_data_i), .dw1_i(rd_data_i), .tag_hit_o(tag_hit), .size_ok_o(size_ok)
  );

  hpt_rights u_rights (
    .dw1_i(dw1_q), .ea_i(ea_q), .psize_i(ps_q), .prob_i(pr_q), .ks_i(ks_q), .kp_i(kp_q),
    .may_read_o(may_read_o), .may_write_o(may_write_o), .may_exec_o(may_exec_o),
    .raddr_o(raddr_o)
  );

  assign ent_addr  = grp_addr + {{(60-IDX_W){1'b0}}, idx_q, 4'h0};
  assign rd_req_o  = (state_q == S_RD0) || (state_q == S_RD1);
  assign rd_addr_o = ent_addr + ((state_q == S_RD1) ? 64'd8 : 64'd0);
  assign wr_req_o  = (state_q == S_WR) || (state_q == S_WC);
  assign wr_addr_o = ent_addr + ((state_q == S_WC) ? 64'd15 : 64'd14);
  assign wr_byte_o = (state_q == S_WC) ? (dw1_q[7:0] | 8'h80) : (dw1_q[15:8] | 8'h01);
  assign need_r    = may_read_o & ~dw1_q[8];
  assign need_c    = wr_q & may_write_o & ~dw1_q[7];
  assign busy_o    = state_q != S_IDLE;
  assign done_o    = state_q == S_FIN;
  assign status_o  = nf_q ? ST_NOT_FOUND
                   : ((~may_read_o | (wr_q & ~may_write_o)) ? ST_PERM : ST_OK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      vsid_q  <= '0;
      t1_q    <= 1'b0;
      ks_q    <= 1'b0;
      kp_q    <= 1'b0;
      pr_q    <= 1'b0;
      wr_q    <= 1'b0;
      sec_q   <= 1'b0;
      nf_q    <= 1'b0;
      ps_q    <= '0;
      ea_q    <= '0;
      hash_q  <= '0;
      cfg_q   <= '0;
      dw1_q   <= '0;
      idx_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          vsid_q  <= seg_vsid_i;
          t1_q    <= seg_1t_i;
          ps_q    <= seg_psize_i;
          ks_q    <= seg_ks_i;
          kp_q    <= seg_kp_i;
          ea_q    <= ea_i;
          hash_q  <= hash_i;
          cfg_q   <= tbl_cfg_i;
          pr_q    <= prob_i;
          wr_q    <= write_i;
          sec_q   <= 1'b0;
          nf_q    <= 1'b0;
          idx_q   <= '0;
          state_q <= S_RD0;
        end
        S_RD0, S_RD1: if (rd_ack_i) begin
          if (state_q == S_RD1) dw1_q <= rd_data_i;
          if (state_q == S_RD0 && tag_hit) begin
            state_q <= S_RD1;
          end else if (state_q == S_RD1 && size_ok) begin
            state_q <= S_EVAL;
          end else if (idx_q != LAST_IDX) begin
            idx_q   <= idx_q + 1'b1;
            state_q <= S_RD0;
          end else if (!sec_q) begin
            sec_q   <= 1'b1;
            idx_q   <= '0;
            state_q <= S_RD0;
          end else begin
            nf_q    <= 1'b1;
            state_q <= S_FIN;
          end
        end
        S_EVAL: state_q <= need_r ? S_WR : (need_c ? S_WC : S_FIN);
        S_WR: if (wr_ack_i) begin
          dw1_q[8] <= 1'b1;
          state_q  <= need_c ? S_WC : S_FIN;
        end
        S_WC: if (wr_ack_i) begin
          dw1_q[7] <= 1'b1;
          state_q  <= S_FIN;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  AST_ONE_PORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_o && wr_req_o)); // R11
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o)); // R11
  AST_DONE_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o); // R11
  AST_WR_BYTE_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> (wr_addr_o[3:0] == 4'he || wr_addr_o[3:0] == 4'hf)); // R8
  AST_C_ON_WRITABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && wr_addr_o[3:0] == 4'hf |-> may_write_o); // R9
  AST_WRITE_IMPLIES_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    may_write_o |-> may_read_o); // R5
  AST_RD_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> rd_addr_o[2:0] == 3'd0); // R1
endmodule

// File: tb/hpt_walker_test.sv
module hpt_walker_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [51:0] vsid = '0;
  logic        t1 = 1'b0, ks = 1'b0, kp = 1'b0, pr = 1'b0, wr = 1'b0;
  logic [1:0]  psize = '0;
  logic [63:0] ea = '0, hash = '0, cfg = '0;
  logic        busy, done, may_r, may_w, may_x, rd_req, wr_req;
  logic [1:0]  status;
  logic [63:0] raddr, rd_addr, wr_addr;
  logic        rd_ack = 1'b0, wr_ack = 1'b0;
  logic [63:0] rd_data = '0;
  logic [7:0]  wr_byte;

  hpt_walker uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .seg_vsid_i(vsid), .seg_1t_i(t1),
    .seg_psize_i(psize), .seg_ks_i(ks), .seg_kp_i(kp), .ea_i(ea), .hash_i(hash),
    .tbl_cfg_i(cfg), .prob_i(pr), .write_i(wr), .busy_o(busy), .done_o(done),
    .status_o(status), .raddr_o(raddr), .may_read_o(may_r), .may_write_o(may_w),
    .may_exec_o(may_x), .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_ack_i(rd_ack),
    .rd_data_i(rd_data), .wr_req_o(wr_req), .wr_addr_o(wr_addr), .wr_byte_o(wr_byte),
    .wr_ack_i(wr_ack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0, cycles = 0;
  logic [63:0] gp [16];
  logic [63:0] gs [16];
  logic [63:0] pri_base, sec_base;
  int n_rd, n_wr;
  logic [63:0] rd_log [40];
  logic [63:0] last_wa;
  logic [7:0]  last_wb;
  logic        busy_seen;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] grp_of(input logic [63:0] h, input logic [63:0] c, input bit sec);
    logic [63:0] hh = sec ? ~h : h;
    logic [63:0] m = (64'd1 << (c[4:0] + 11)) - 1;
    return (((hh & 64'h7f_ffff_ffff) & m) << 7) | (c & ~64'h3ffff);
  endfunction

  function automatic logic [63:0] tag_word(input logic [51:0] vs, input logic [63:0] e,
                                           input bit one_t, input int ps, input bit sec);
    int p = (ps == 0) ? 12 : ((ps == 1) ? 16 : 24);
    int sh = one_t ? 40 : 28;
    logic [63:0] a = ((e & ((64'd1 << sh) - 1)) >> p) | ({12'd0, vs} << (sh - p));
    if (p < 16) a = a >> (16 - p); else a = a << (p - 16);
    return (a & 64'h3fff_ffff_ffff_ff80) | (one_t ? 64'h4000_0000_0000_0000 : 64'd0)
         | ((ps != 0) ? 64'd4 : 64'd0) | 64'd1 | (sec ? 64'd2 : 64'd0);
  endfunction

  function automatic logic [63:0] mem_rd(input logic [63:0] a);
    if (a >= pri_base && a < pri_base + 128) return gp[int'((a - pri_base) >> 3)];
    if (a >= sec_base && a < sec_base + 128) return gs[int'((a - sec_base) >> 3)];
    return 64'd0;
  endfunction

  always @(negedge clk) begin
    if (rd_req && !rd_ack) begin
      rd_ack = 1'b1;
      rd_data = mem_rd(rd_addr);
      if (n_rd < 40) rd_log[n_rd] = rd_addr;
      n_rd++;
    end else rd_ack = 1'b0;
    if (wr_req && !wr_ack) begin
      wr_ack = 1'b1;
      last_wa = wr_addr;
      last_wb = wr_byte;
      n_wr++;
      if (wr_addr >= pri_base && wr_addr < pri_base + 128)
        gp[int'((wr_addr - pri_base) >> 3)][(7 - int'(wr_addr[2:0])) * 8 +: 8] = wr_byte;
    end else wr_ack = 1'b0;
  end

  task automatic setup(input logic [63:0] h, input logic [63:0] c);
    hash = h; cfg = c;
    pri_base = grp_of(h, c, 1'b0);
    sec_base = grp_of(h, c, 1'b1);
    for (int i = 0; i < 16; i++) begin gp[i] = '0; gs[i] = '0; end
    vsid = 52'h12345; ea = 64'h0abc_d123; t1 = 0; psize = 0;
    ks = 0; kp = 0; pr = 0; wr = 0;
  endtask

  task automatic walk();
    n_rd = 0; n_wr = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; busy_seen = busy;
    while (!done) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11 reset busy", busy, 0);
    chk("R11 reset done", done, 0);
    chk("R11 reset req", {rd_req, wr_req}, 0);
  endtask

  task automatic t_primary_read();
    setup(64'h5, 64'h4_0000);
    gp[2] = tag_word(vsid, ea, 0, 0, 0) & ~64'd1;
    gp[6] = tag_word(vsid, ea, 0, 0, 0); gp[7] = 64'h0777_7002;
    gp[10] = tag_word(vsid, ea, 0, 0, 0); gp[11] = 64'h0555_5002;
    walk();
    chk("R11 busy after start", busy_seen, 1);
    chk("R1 first read addr", rd_log[0], 64'h4_0280);
    chk("R10 status ok", status, 0);
    chk("R2 first hit slot3 raddr", raddr, 64'h0777_7123);
    chk("R5 rw code 2", {may_r, may_w}, 2'b11);
    chk("R6 exec allowed", may_x, 1);
    chk("R8 R write count", n_wr, 1);
    chk("R8 R write addr", last_wa, 64'h4_02be);
    chk("R8 R write byte", last_wb, 8'h71);
    @(negedge clk);
    chk("R11 done one cycle", {done, busy}, 2'b00);
  endtask

  task automatic t_write_rc();
    setup(64'h5, 64'h4_0000);
    wr = 1;
    gp[6] = tag_word(vsid, ea, 0, 0, 0); gp[7] = 64'h0777_7000;
    walk();
    chk("R10 write ok", status, 0);
    chk("R9 two writes", n_wr, 2);
    chk("R9 C write addr", last_wa, 64'h4_02bf);
    chk("R9 C write byte", last_wb, 8'h80);
    chk("R9 memory R and C set", gp[7], 64'h0777_7180);
  endtask

  task automatic t_secondary();
    setup(64'h5, 64'h4_0000);
    gs[0] = tag_word(vsid, ea, 0, 0, 0);
    gs[1] = 64'h0111_1102;
    gs[10] = tag_word(vsid, ea, 0, 0, 1); gs[11] = 64'h0333_3102;
    walk();
    chk("R3 secondary first addr", rd_log[8], 64'h7_fd00);
    chk("R3 secondary hit", status, 0);
    chk("R3 H bit required raddr", raddr, 64'h0333_3123);
  endtask

  task automatic t_not_found();
    setup(64'h5, 64'h4_0000);
    gp[0] = tag_word(vsid, ea, 0, 0, 1);
    walk();
    chk("R3 not found", status, 1);
    chk("R3 sixteen reads", n_rd, 16);
    chk("R8 no write on miss", n_wr, 0);
  endtask

  task automatic t_perm();
    setup(64'h5, 64'h4_0000);
    pr = 1; kp = 1;
    gp[0] = tag_word(vsid, ea, 0, 0, 0); gp[1] = 64'h0777_7000;
    walk();
    chk("R5 code 4 no rights", {may_r, may_w}, 2'b00);
    chk("R10 read perm", status, 2);
    chk("R8 no R write when unreadable", n_wr, 0);
    setup(64'h5, 64'h4_0000);
    wr = 1;
    gp[0] = tag_word(vsid, ea, 0, 0, 0); gp[1] = 64'h8000_0000_0777_7102;
    walk();
    chk("R5 code 10 read only", {may_r, may_w}, 2'b10);
    chk("R10 write perm", status, 2);
    chk("R9 no C write", n_wr, 0);
    setup(64'h5, 64'h4_0000);
    ks = 1;
    gp[0] = tag_word(vsid, ea, 0, 0, 0); gp[1] = 64'h0777_7103;
    walk();
    chk("R5 code 7 read only", {may_r, may_w, status}, 4'b1000);
    setup(64'h5, 64'h4_0000);
    ks = 1; wr = 1;
    gp[0] = tag_word(vsid, ea, 0, 0, 0); gp[1] = 64'h0777_7182;
    walk();
    chk("R5 code 6 read write", {may_r, may_w, status}, 4'b1100);
    chk("R9 no write when R C set", n_wr, 0);
  endtask

  task automatic t_large();
    setup(64'h5, 64'h4_0000);
    psize = 2;
    gp[2] = tag_word(vsid, ea, 0, 2, 0); gp[3] = 64'h0100_1100;
    gp[4] = tag_word(vsid, ea, 0, 2, 0); gp[5] = 64'h0500_0101;
    walk();
    chk("R4 16M bad size skipped", raddr, 64'h05bc_d123);
    chk("R7 16M status", status, 0);
    setup(64'h5, 64'h4_0000);
    psize = 1;
    gp[0] = tag_word(vsid, ea, 0, 1, 0); gp[1] = 64'h0900_0101;
    gp[8] = tag_word(vsid, ea, 0, 1, 0); gp[9] = 64'h0900_1101;
    walk();
    chk("R4 R7 64K raddr", raddr, 64'h0900_d123);
  endtask

  task automatic t_exec_1t();
    setup(64'h5, 64'h4_0000);
    gp[0] = tag_word(vsid, ea, 0, 0, 0); gp[1] = 64'h0777_7106;
    walk();
    chk("R6 no-execute", may_x, 0);
    setup(64'h5, 64'h4_0000);
    t1 = 1; vsid = 52'h2a; ea = 64'h12_3456_7123;
    gp[0] = tag_word(vsid, ea, 0, 0, 0); gp[1] = 64'h0111_1102;
    gp[4] = tag_word(vsid, ea, 1, 0, 0); gp[5] = 64'h0444_4102;
    walk();
    chk("R2 1T segment field", raddr, 64'h0444_4123);
  endtask

  task automatic t_size_mask();
    setup(64'h0000_0180_0000_0005, 64'h1f);
    walk();
    chk("R1 hash cut to 39 bits", rd_log[0], 64'h280);
    chk("R1 secondary group addr", rd_log[8], 64'h3f_ffff_fffd_00);
    chk("R3 not found large table", status, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_primary_read();
    t_write_rc();
    t_secondary();
    t_not_found();
    t_perm();
    t_large();
    t_exec_1t();
    t_size_mask();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    while (cycles < 100000) begin @(posedge clk); cycles++; end
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=<100000", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule